// File: doc/BRIEF.md
# Serial ADC Acquisition Adapter

This block sits between a chip's parallel logic and an external 8-bit successive-approximation converter whose result leaves the converter on a serial line. A rising edge on the sample request input starts one acquisition. The block then runs through three phases in order. First it holds the active-low convert-start line low for a set number of system clocks. Next it waits a set number of clocks so the converter can finish its internal conversion, which takes a few microseconds. Finally it issues eight serial clock pulses and reads one data bit on each rising edge, most significant bit first.

Once all eight bits are in, the assembled byte appears on the parallel result port and a one-clock data-ready pulse marks it. The result uses straight binary coding: code N stands for N/256 of the converter's reference voltage. Request edges that arrive while an acquisition is running are dropped, so the consumer sees exactly one result per accepted request. The start pulse length, the conversion wait and the serial clock half period are parameters counted in system clocks. One acquisition takes START_LOW + CONV_WAIT + 16·SCLK_HALF clocks, which can be set to match a converter that allows about 185 k samples per second.

Top module: `serial_adc_capture`

## Requirements
- R1: During and right after reset, convStartN is 1, sclk is 0, result is 0 and dataReady is 0.
- R2: A rising edge of sampleReq seen at a clock edge while the block is idle starts an acquisition. convStartN is 0 for exactly START_LOW cycles, beginning in the cycle after that edge.
- R3: After the start pulse, convStartN returns to 1 and sclk stays 0 for exactly CONV_WAIT cycles before the first serial clock pulse.
- R4: An acquisition issues exactly 8 sclk pulses. Each pulse has a low phase of SCLK_HALF cycles followed by a high phase of SCLK_HALF cycles, and sclk is 0 whenever the block is idle.
- R5: sdi is captured at the clock edge where sclk goes from 0 to 1. The first captured bit becomes result bit 7 and the last becomes bit 0, so the byte is plain straight binary (0x00 for all-zero bits, 0xFF for all-one bits).
- R6: At the clock edge that ends the eighth high phase, result takes the new byte and dataReady is 1 for exactly one cycle. At all other times result holds its value.
- R7: sampleReq edges that occur while an acquisition is running have no effect: no extra start pulse, no extra sclk pulses, and no change to the timing of the running acquisition. A request held high does not start a second acquisition.
- R8: A rising edge of sampleReq at the clock edge right after the one that raised dataReady is accepted and starts a new acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleReq | input | 1 | Acquisition request; its rising edge starts a conversion |
| sdi | input | 1 | Serial data from the converter |
| convStartN | output | 1 | Active-low convert-start line to the converter |
| sclk | output | 1 | Serial clock to the converter |
| result | output | 8 | Last received conversion byte, straight binary |
| dataReady | output | 1 | One-cycle strobe marking a new result |

## Verification
Call the clock edge that sees the request rise edge 0. Then convStartN is low after edges 0 to START_LOW-1. The n-th sclk rise (n counting from 0) follows edge START_LOW+CONV_WAIT+SCLK_HALF·(2n+1). The result and dataReady change after edge START_LOW+CONV_WAIT+16·SCLK_HALF. The bench keeps a behavioural model that counts edges since the accepted request and derives every output's expected value for each cycle from that count. It compares all four outputs at each falling clock edge, half a cycle after the design's registers have settled, so every delay above is checked to the exact cycle.

// File: rtl/acq_pkg.sv
package acq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2,
    ST_SHIFT = 2'd3
  } acqState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;  // take sdi into the shift register at this edge
    logic load;     // move the assembled byte to the output at this edge
  } acqStrobe_t;

endpackage

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int START_LOW  = 4,
  parameter int CONV_WAIT  = 800,
  parameter int SCLK_HALF  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleReq,
  output logic       convStartN,
  output logic       sclk,
  output acqStrobe_t strb
);

  localparam int MAX_A   = (START_LOW > CONV_WAIT) ? START_LOW : CONV_WAIT;
  localparam int MAX_CNT = (MAX_A > SCLK_HALF) ? MAX_A : SCLK_HALF;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam int BIT_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_LOW - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(CONV_WAIT - 1);
  localparam logic [CNT_W-1:0] HALF_LAST  = CNT_W'(SCLK_HALF - 1);
  localparam logic [BIT_W-1:0] BIT_LAST   = BIT_W'(DATA_W - 1);

  acqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitIdx;
  logic             sclkQ;
  logic             sampPrev;
  logic             sampleRise;
  logic             halfDone;

  assign sampleRise = sampleReq & ~sampPrev;
  assign halfDone   = (cnt == HALF_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitIdx   <= '0;
      sclkQ    <= 1'b0;
      sampPrev <= 1'b0;
    end else begin
      sampPrev <= sampleReq;
      unique case (state)
        ST_IDLE: begin
          if (sampleRise) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_START: begin
          if (cnt == START_LAST) begin
            state <= ST_WAIT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (cnt == WAIT_LAST) begin
            state  <= ST_SHIFT;
            cnt    <= '0;
            bitIdx <= '0;
            sclkQ  <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (halfDone) begin
            cnt <= '0;
            if (!sclkQ) begin
              sclkQ <= 1'b1;
            end else begin
              sclkQ <= 1'b0;
              if (bitIdx == BIT_LAST) begin
                state <= ST_IDLE;
              end else begin
                bitIdx <= bitIdx + 1'b1;
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.capture = (state == ST_SHIFT) && halfDone && !sclkQ;
    strb.load    = (state == ST_SHIFT) && halfDone && sclkQ && (bitIdx == BIT_LAST);
  end

  assign convStartN = (state != ST_START);
  assign sclk       = sclkQ;

  // R4: no serial clock while convert-start is asserted
  p_sclk_quiet_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    !convStartN |-> !sclk);

  // R2: a start pulse only begins after a request rise was seen
  p_start_on_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convStartN) |-> ($past(sampleReq) && !$past(sampPrev)));

  // R5: every sclk rise coincides with a capture strobe
  p_rise_captures_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> $past(strb.capture));

  // R3: the serial clock never rises straight out of the start pulse
  p_wait_before_clock_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convStartN) |-> !sclk);

endmodule

// File: rtl/acq_datapath.sv
module acq_datapath
  import acq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdi,
  input  acqStrobe_t        strb,
  output logic [DATA_W-1:0] result,
  output logic              dataReady
);

  localparam int CAP_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] shiftReg;
  logic [CAP_W-1:0]  capCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      result    <= '0;
      dataReady <= 1'b0;
      capCnt    <= '0;
    end else begin
      dataReady <= 1'b0;
      if (strb.capture) begin
        shiftReg <= {shiftReg[DATA_W-2:0], sdi};
        capCnt   <= capCnt + 1'b1;
      end
      if (strb.load) begin
        result    <= shiftReg;
        dataReady <= 1'b1;
        capCnt    <= '0;
      end
    end
  end

  // R4: the byte is only handed over after exactly DATA_W captures
  p_full_byte_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> (capCnt == CAP_W'(DATA_W)));

  // R6: data-ready is a single-cycle pulse
  p_ready_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |=> !dataReady);

  // R6: result only moves together with data-ready
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !dataReady |-> $stable(result));

endmodule

// File: rtl/serial_adc_capture.sv
module serial_adc_capture
  import acq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int START_LOW = 4,
  parameter int CONV_WAIT = 800,
  parameter int SCLK_HALF = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleReq,
  input  logic              sdi,
  output logic              convStartN,
  output logic              sclk,
  output logic [DATA_W-1:0] result,
  output logic              dataReady
);

  acqStrobe_t strb;

  acq_ctrl #(
    .DATA_W   (DATA_W),
    .START_LOW(START_LOW),
    .CONV_WAIT(CONV_WAIT),
    .SCLK_HALF(SCLK_HALF)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleReq (sampleReq),
    .convStartN(convStartN),
    .sclk      (sclk),
    .strb      (strb)
  );

  acq_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sdi      (sdi),
    .strb     (strb),
    .result   (result),
    .dataReady(dataReady)
  );

  // R1: outputs idle while reset is held
  always_comb begin
    if (!rstN) begin
      a_reset_idle_r1: assert (convStartN && !sclk && !dataReady);
    end
  end

endmodule

// File: tb/serial_adc_capture_test.sv
`timescale 1ns/1ps
module serial_adc_capture_test;

  localparam int SL   = 3;
  localparam int CW   = 10;
  localparam int HF   = 2;
  localparam int BASE = SL + CW;
  localparam int LAT  = BASE + 16 * HF;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleReq = 1'b0;
  logic       sdi = 1'b0;
  logic       convStartN;
  logic       sclk;
  logic [7:0] result;
  logic       dataReady;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  serial_adc_capture #(
    .DATA_W(8), .START_LOW(SL), .CONV_WAIT(CW), .SCLK_HALF(HF)
  ) uut (
    .clk(clk), .rstN(rstN), .sampleReq(sampleReq), .sdi(sdi),
    .convStartN(convStartN), .sclk(sclk), .result(result), .dataReady(dataReady)
  );

  // Converter stand-in: MSB presented at start, next bit after each sclk fall
  logic [7:0] adcWord = 8'h00;
  int bitPtr = 7;
  always @(negedge convStartN) begin bitPtr = 7; sdi = adcWord[7]; end
  always @(negedge sclk) if (bitPtr > 0) begin bitPtr = bitPtr - 1; sdi = adcWord[bitPtr]; end

  int sclkRises = 0;
  int startFalls = 0;
  always @(posedge sclk) sclkRises++;
  always @(negedge convStartN) startFalls++;

  // Behavioural reference: edges counted since the accepted request
  bit       mBusy = 0;
  int       mAge = 0;
  bit       mPrev = 0;
  bit       mDone = 0;
  logic [7:0] mCap = 0;
  logic [7:0] mResult = 0;

  always @(posedge clk) begin
    mDone = 0;
    if (!rstN) begin
      mBusy = 0; mAge = 0; mPrev = 0; mCap = 0; mResult = 0;
    end else begin
      if (mBusy) begin
        int n;
        int s;
        n = mAge + 1;
        s = n - BASE;
        if (s > 0 && (s % (2 * HF)) == HF) mCap = {mCap[6:0], sdi};
        mAge = n;
        if (n == LAT) begin
          mBusy = 0; mDone = 1; mResult = mCap;
        end
      end else if (sampleReq && !mPrev) begin
        mBusy = 1; mAge = 0; mCap = 0;
      end
      mPrev = sampleReq;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, half a cycle after the active edge
  always @(negedge clk) begin
    if (rstN) begin
      bit eConv;
      bit eSclk;
      eConv = 1; eSclk = 0;
      if (mBusy) begin
        int s;
        s = mAge - BASE;
        eConv = !(mAge < SL);
        eSclk = (s >= 0) && (s < 16 * HF) && (((s / HF) % 2) == 1);
      end
      check("R2/R3 convStartN", convStartN, eConv);
      check("R4 sclk", sclk, eSclk);
      check("R6 dataReady", dataReady, mDone);
      check("R5/R6 result", result, mResult);
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", wd);
      finishRun();
    end
  end

  task automatic acquire(input logic [7:0] word, input string tag);
    int r0;
    int f0;
    adcWord = word;
    r0 = sclkRises; f0 = startFalls;
    @(negedge clk); sampleReq = 1'b1;
    @(negedge clk); sampleReq = 1'b0;
    while (!dataReady) @(negedge clk);
    check({tag, " result"}, result, word);
    check("R4 eight sclk pulses", sclkRises - r0, 8);
    check("R2 one start pulse", startFalls - f0, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state while reset held
    check("R1 convStartN", convStartN, 1);
    check("R1 sclk", sclk, 0);
    check("R1 result", result, 0);
    check("R1 dataReady", dataReady, 0);
    @(negedge clk); rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle after reset", {convStartN, sclk, dataReady}, 3'b100);

    acquire(8'hA5, "R5 pattern A5");
    acquire(8'h00, "R5 all zeros");
    acquire(8'hFF, "R5 all ones");
    acquire(8'h81, "R5 end bits");
    acquire(8'h3C, "R5 pattern 3C");

    // R7: extra request edges during a running acquisition
    begin
      int r0;
      int f0;
      adcWord = 8'h5A; r0 = sclkRises; f0 = startFalls;
      @(negedge clk); sampleReq = 1'b1;
      @(negedge clk); sampleReq = 1'b0;
      repeat (4) @(negedge clk); sampleReq = 1'b1;
      @(negedge clk); sampleReq = 1'b0;
      repeat (20) @(negedge clk); sampleReq = 1'b1;
      @(negedge clk); sampleReq = 1'b0;
      while (!dataReady) @(negedge clk);
      check("R7 result unaffected", result, 8'h5A);
      repeat (10) @(negedge clk);
      check("R7 no extra start", startFalls - f0, 1);
      check("R7 no extra sclk", sclkRises - r0, 8);
    end

    // R7: request held high starts only one acquisition
    begin
      int f0;
      adcWord = 8'hC3; f0 = startFalls;
      @(negedge clk); sampleReq = 1'b1;
      repeat (3 * LAT) @(negedge clk);
      check("R7 held request", startFalls - f0, 1);
      check("R7 held request result", result, 8'hC3);
      sampleReq = 1'b0;
    end

    // R8: new request right after the ready edge
    begin
      int f0;
      adcWord = 8'h96;
      @(negedge clk); sampleReq = 1'b1;
      @(negedge clk); sampleReq = 1'b0;
      while (!dataReady) @(negedge clk);
      f0 = startFalls;
      adcWord = 8'h69;
      sampleReq = 1'b1;
      @(negedge clk); sampleReq = 1'b0;
      check("R8 back-to-back start", startFalls - f0, 1);
      while (!dataReady) @(negedge clk);
      check("R8 second result", result, 8'h69);
    end

    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule